// File: doc/BRIEF.md
# Addressed Serial Frame Receiver

This block sits on a shared multidrop serial line. It picks out the frames meant for this station. The line idles high. Every frame is 11 bits long: a low start bit, eight data bits sent least significant bit first, an even-parity bit, and a high stop bit. The top data bit (bit 7) gives the frame type: 1 means an address frame and 0 means a command frame. The other seven data bits carry the payload.

An address frame is accepted when it is clean (correct parity and a stop bit present). If its payload equals the 7-bit strap input, the block arms its valid-address latch and gives a one-cycle valid-address pulse. If the payload differs, the latch is disarmed. A clean command frame that arrives while the latch is armed is copied to the parallel command outputs, together with a one-cycle command strobe. The armed flag is exported so that a companion transmitter can tell that this station has been addressed.

Bit timing runs from an oversampling clock enable, `os_en`. One bit lasts `TICKS_PER_BIT` enabled cycles. Bits are sampled at their centre, counted from the half-bit point at which the start bit is confirmed.

The receive state machine has six states:
- IDLE goes to START on a low line.
- START goes back to IDLE if the line is high at the half-bit point, and goes to DATA if it is low.
- DATA goes to PARITY after eight samples.
- PARITY goes to STOP.
- STOP goes to IDLE when the stop bit is high, and to WAIT_HIGH when it is low.
- WAIT_HIGH goes to IDLE once the line is high again.

The sequencer has two states:
- UNARMED goes to ARMED on a clean, matching address frame.
- ARMED goes to UNARMED on a clean, non-matching address frame.
- ARMED stays ARMED on a clean command frame, which is latched.

Top module: `addr_frame_rx`

## Requirements
- R1: While reset is active and just after it is released, `vap_o`, `cs_o` and `armed_o` are 0 and `cmd_o` is all zeros. Asserting reset at any time returns the block to this state.
- R2: A clean frame with data bit 7 = 1 whose bits 0..6, sent least significant bit first, equal `strap_i` gives exactly one `vap_o` pulse and sets `armed_o` to 1.
- R3: A clean frame with bit 7 = 1 whose bits 0..6 differ from `strap_i` gives no `vap_o` pulse and clears `armed_o` to 0.
- R4: A clean frame with bit 7 = 0 that arrives while `armed_o` is 1 drives its bits 0..6 onto `cmd_o` and gives exactly one `cs_o` pulse. `armed_o` stays 1. `cmd_o` changes only together with a `cs_o` pulse.
- R5: A command frame that arrives while `armed_o` is 0 is ignored: there is no `cs_o` pulse and `cmd_o` keeps its value.
- R6: A frame whose parity bit does not make the count of ones across the eight data bits plus the parity bit even is discarded: there is no pulse, and `cmd_o` and `armed_o` are unchanged.
- R7: A frame whose stop bit is low is discarded. The receiver waits for the line to return high before it looks for the next start bit, and it then accepts the next frame normally.
- R8: A low level that is gone by the half-bit point of a would-be start bit is rejected: there is no pulse and no output change. A following frame is received normally.
- R9: `vap_o` and `cs_o` are each high for exactly one clock cycle per event.
- R10: Bit timing counts only cycles with `os_en` high. With `os_en` high on every other cycle, frames whose bits last `2*TICKS_PER_BIT` clocks are received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_en | input | 1 | Oversampling clock enable; one bit = TICKS_PER_BIT enabled cycles |
| rx_i | input | 1 | Serial line, idles high (asynchronous, synchronised inside) |
| strap_i | input | ADDR_W | Station address strap |
| vap_o | output | 1 | Valid-address pulse |
| cs_o | output | 1 | Command strobe |
| cmd_o | output | ADDR_W | Latched command payload |
| armed_o | output | 1 | Valid-address latch, exported for a transmitter |

## Verification
The sweep sends every one of the 128 address codes against a fixed strap. Each address frame is followed by a command frame whose payload is computed from that address, so the single match is separated from 127 mismatches. The same sweep shows that commands are accepted only after the matching address and are dropped after every other one. Edge straps of all-zeros and all-ones expose bit-order and bit-width mistakes. Targeted frames with a flipped parity bit or a low stop bit, and a short start glitch, each check that a bad frame changes nothing. A final run with the clock enable at half rate confirms that the bit timing follows the enable and not the clock.

// File: rtl/afr_pkg.sv
package afr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef enum logic [0:0] {
        SQ_UNARMED,
        SQ_ARMED
    } seq_state_e;

endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], d_i};
    end

    assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/afr_rx_fsm.sv
module afr_rx_fsm
    import afr_pkg::*;
#(
    parameter int TICKS_PER_BIT = 64,
    parameter int DATA_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_en,
    input  logic                 rx_i,
    output logic                 frame_vld_o,
    output logic [DATA_BITS-1:0] frame_data_o,
    output logic                 par_ok_o,
    output logic                 stop_ok_o
);
    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam int IW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] HALF_LAST = CW'(TICKS_PER_BIT / 2 - 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(TICKS_PER_BIT - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_BITS - 1);

    rx_state_e            state_q, state_d;
    logic [CW-1:0]        cnt_q, cnt_d;
    logic [IW-1:0]        idx_q, idx_d;
    logic [DATA_BITS-1:0] sh_q, sh_d;
    logic                 par_q, par_d;
    logic                 vld_q, vld_d;
    logic                 stop_q, stop_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            par_q   <= 1'b0;
            vld_q   <= 1'b0;
            stop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
            par_q   <= par_d;
            vld_q   <= vld_d;
            stop_q  <= stop_d;
        end
    end

    // next state and sampling
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        par_d   = par_q;
        vld_d   = 1'b0;
        stop_d  = stop_q;
        if (os_en) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!rx_i) begin
                        state_d = ST_START;
                        cnt_d   = '0;
                    end
                end
                ST_START: begin
                    if (cnt_q == HALF_LAST) begin
                        cnt_d   = '0;
                        idx_d   = '0;
                        state_d = rx_i ? ST_IDLE : ST_DATA;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (cnt_q == FULL_LAST) begin
                        cnt_d = '0;
                        sh_d  = {rx_i, sh_q[DATA_BITS-1:1]};
                        if (idx_q == IDX_LAST) state_d = ST_PARITY;
                        else                   idx_d   = idx_q + 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (cnt_q == FULL_LAST) begin
                        cnt_d   = '0;
                        par_d   = rx_i;
                        state_d = ST_STOP;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cnt_q == FULL_LAST) begin
                        cnt_d   = '0;
                        vld_d   = 1'b1;
                        stop_d  = rx_i;
                        state_d = rx_i ? ST_IDLE : ST_WAIT_HIGH;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (rx_i) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign frame_vld_o  = vld_q;
    assign frame_data_o = sh_q;
    assign par_ok_o     = ~(^{sh_q, par_q});
    assign stop_ok_o    = stop_q;

    // R10: a completed frame is only reported after an enabled cycle
    a_r10_frame_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |-> $past(os_en));

    // R7: a frame is reported only from the stop-bit state
    a_r7_frame_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |-> $past(state_q == ST_STOP));
endmodule

// File: rtl/afr_seq_ctrl.sv
module afr_seq_ctrl
    import afr_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_vld_i,
    input  logic [ADDR_W:0]   frame_data_i,
    input  logic              par_ok_i,
    input  logic              stop_ok_i,
    input  logic [ADDR_W-1:0] strap_i,
    output logic              vap_o,
    output logic              cs_o,
    output logic [ADDR_W-1:0] cmd_o,
    output logic              armed_o
);
    seq_state_e        seq_q, seq_d;
    logic              vap_q, vap_d;
    logic              cs_q, cs_d;
    logic [ADDR_W-1:0] cmd_q, cmd_d;

    logic clean, is_addr, match;
    assign clean   = frame_vld_i && par_ok_i && stop_ok_i;
    assign is_addr = frame_data_i[ADDR_W];
    assign match   = (frame_data_i[ADDR_W-1:0] == strap_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SQ_UNARMED;
            vap_q <= 1'b0;
            cs_q  <= 1'b0;
            cmd_q <= '0;
        end else begin
            seq_q <= seq_d;
            vap_q <= vap_d;
            cs_q  <= cs_d;
            cmd_q <= cmd_d;
        end
    end

    always_comb begin
        seq_d = seq_q;
        vap_d = 1'b0;
        cs_d  = 1'b0;
        cmd_d = cmd_q;
        unique case (seq_q)
            SQ_UNARMED: begin
                if (clean && is_addr && match) begin
                    seq_d = SQ_ARMED;
                    vap_d = 1'b1;
                end
            end
            SQ_ARMED: begin
                if (clean && is_addr) begin
                    if (match) vap_d = 1'b1;
                    else       seq_d = SQ_UNARMED;
                end else if (clean) begin
                    cs_d  = 1'b1;
                    cmd_d = frame_data_i[ADDR_W-1:0];
                end
            end
            default: seq_d = SQ_UNARMED;
        endcase
    end

    assign vap_o   = vap_q;
    assign cs_o    = cs_q;
    assign cmd_o   = cmd_q;
    assign armed_o = (seq_q == SQ_ARMED);

    a_r9_vap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vap_o |=> !vap_o);

    a_r9_cs_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |=> !cs_o);

    // R5: a strobe only follows a cycle in which the latch was armed
    a_r5_cs_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> $past(armed_o));

    // R2: the address pulse leaves the latch armed
    a_r2_vap_arms: assert property (@(posedge clk) disable iff (!rst_n)
        vap_o |-> armed_o);

    // R6: a strobe is preceded by a clean frame report
    a_r6_cs_clean_frame: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> $past(par_ok_i && stop_ok_i && frame_vld_i));

    // R4: the command outputs move only together with the strobe
    a_r4_cmd_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_o |-> $stable(cmd_o));
endmodule

// File: rtl/addr_frame_rx.sv
module addr_frame_rx #(
    parameter int TICKS_PER_BIT = 64,
    parameter int ADDR_W        = 7,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_en,
    input  logic              rx_i,
    input  logic [ADDR_W-1:0] strap_i,
    output logic              vap_o,
    output logic              cs_o,
    output logic [ADDR_W-1:0] cmd_o,
    output logic              armed_o
);
    localparam int DATA_BITS = ADDR_W + 1;

    logic                 rx_s;
    logic                 frame_vld;
    logic [DATA_BITS-1:0] frame_data;
    logic                 par_ok;
    logic                 stop_ok;

    afr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    afr_rx_fsm #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .DATA_BITS     (DATA_BITS)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .os_en        (os_en),
        .rx_i         (rx_s),
        .frame_vld_o  (frame_vld),
        .frame_data_o (frame_data),
        .par_ok_o     (par_ok),
        .stop_ok_o    (stop_ok)
    );

    afr_seq_ctrl #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_vld_i  (frame_vld),
        .frame_data_i (frame_data),
        .par_ok_i     (par_ok),
        .stop_ok_i    (stop_ok),
        .strap_i      (strap_i),
        .vap_o        (vap_o),
        .cs_o         (cs_o),
        .cmd_o        (cmd_o),
        .armed_o      (armed_o)
    );
endmodule

// File: tb/addr_frame_rx_tb_top.sv
`timescale 1ns/1ps
module addr_frame_rx_tb_top;
    localparam int TPB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_en = 1'b1;
    logic       rx = 1'b1;
    logic [6:0] strap = 7'h5A;
    logic       vap, cs, armed;
    logic [6:0] cmd;

    int  errs = 0, checks = 0;
    int  vap_cnt = 0, cs_cnt = 0, wid_err = 0;
    bit  vap_prev = 0, cs_prev = 0;
    bit  slow = 0, done = 0;
    bit       arm_m = 0;
    bit [6:0] cmd_m = '0;

    always #2.5 clk = ~clk;

    addr_frame_rx #(.TICKS_PER_BIT(TPB)) dut_i (
        .clk(clk), .rst_n(rst_n), .os_en(os_en), .rx_i(rx), .strap_i(strap),
        .vap_o(vap), .cs_o(cs), .cmd_o(cmd), .armed_o(armed)
    );

    always @(negedge clk) os_en <= slow ? ~os_en : 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (vap) vap_cnt++;
            if (cs)  cs_cnt++;
            if ((vap && vap_prev) || (cs && cs_prev)) wid_err++;
        end
        vap_prev = vap;
        cs_prev  = cs;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(bit [7:0] d, bit bad_par, bit bad_stop);
        bit [10:0] bits;
        int per;
        per = slow ? 2 * TPB : TPB;
        bits = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
        vap_cnt = 0;
        cs_cnt  = 0;
        for (int i = 0; i < 11; i++) begin
            rx = bits[i];
            hold(per);
        end
        rx = 1'b1;
        hold(per + 6);
    endtask

    // Sends one frame and checks the outcome against the bench model
    task automatic frame_chk(bit [7:0] d, bit bad_par, bit bad_stop, string req);
        bit clean, exp_vap, exp_cs;
        clean   = !bad_par && !bad_stop;
        exp_vap = clean && d[7] && (d[6:0] == strap);
        exp_cs  = clean && !d[7] && arm_m;
        if (clean && d[7]) arm_m = exp_vap;
        if (exp_cs) cmd_m = d[6:0];
        send_frame(d, bad_par, bad_stop);
        chk(vap_cnt == int'(exp_vap), {req, " vap count"}, vap_cnt, int'(exp_vap));
        chk(cs_cnt == int'(exp_cs), {req, " cs count"}, cs_cnt, int'(exp_cs));
        chk(cmd == cmd_m, {req, " cmd"}, int'(cmd), int'(cmd_m));
        chk(armed == arm_m, {req, " armed"}, int'(armed), int'(arm_m));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        hold(4);
        arm_m = 0;
        cmd_m = '0;
        chk(!vap && !cs && !armed && cmd == 0, "R1 reset state", int'({vap, cs, armed, cmd}), 0);
        rst_n = 1'b1;
        hold(3);
        chk(!vap && !cs && !armed && cmd == 0, "R1 after release", int'({vap, cs, armed, cmd}), 0);
    endtask

    initial begin
        do_reset();

        // R2 R3 R4 R5: every address, each followed by a command
        for (int a = 0; a < 128; a++) begin
            frame_chk({1'b1, 7'(a)}, 0, 0, (a == 'h5A) ? "R2 match" : "R3 mismatch");
            frame_chk({1'b0, 7'((a * 37 + 11) & 127)}, 0, 0, arm_m ? "R4 command" : "R5 unarmed command");
        end

        // R2 R4 edge straps
        strap = 7'h00;
        frame_chk(8'h80, 0, 0, "R2 strap zero");
        frame_chk(8'h7F, 0, 0, "R4 all-ones command");
        strap = 7'h7F;
        frame_chk(8'h80, 0, 0, "R3 disarm");
        frame_chk(8'hFF, 0, 0, "R2 strap ones");
        frame_chk(8'h00, 0, 0, "R4 zero command");

        // R6 parity errors
        frame_chk(8'h55, 1, 0, "R6 bad parity command");
        frame_chk(8'h81, 1, 0, "R6 bad parity mismatch addr");
        frame_chk(8'h2A, 0, 0, "R4 after parity error");

        // R7 missing stop bit and recovery
        frame_chk(8'h33, 0, 1, "R7 bad stop command");
        frame_chk(8'h90, 0, 1, "R7 bad stop mismatch addr");
        frame_chk(8'h4C, 0, 0, "R7 recovery");

        // R8 short start glitch
        vap_cnt = 0; cs_cnt = 0;
        rx = 1'b0; hold(TPB / 4);
        rx = 1'b1; hold(2 * TPB);
        chk(vap_cnt == 0 && cs_cnt == 0, "R8 glitch pulses", vap_cnt + cs_cnt, 0);
        chk(cmd == cmd_m && armed == arm_m, "R8 glitch state", int'({armed, cmd}), int'({arm_m, cmd_m}));
        frame_chk(8'h19, 0, 0, "R8 frame after glitch");

        // R5 unarmed after reset ignores a command
        do_reset();
        frame_chk(8'h6E, 0, 0, "R5 command after reset");

        // R10 half-rate enable
        slow = 1;
        hold(4);
        frame_chk(8'hFF, 0, 0, "R10 slow address");
        frame_chk(8'h3C, 0, 0, "R10 slow command");
        slow = 0;
        hold(4);

        // R1 reset mid-run clears an armed latch and command
        do_reset();

        chk(wid_err == 0, "R9 pulse width", wid_err, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule